// File: doc/BRIEF.md
# Sixteen-Bit Multi-Cycle Processor Core

This block is a small sequential processor that runs a fixed sixteen-bit instruction set. Code and data share one external memory of 256 sixteen-bit words. The core drives a word address and a write strobe, and it reads data combinationally in the same cycle. After reset it starts at word 0. Each instruction takes two clock cycles: one fetches the instruction word into an instruction register, and one decodes and executes it and then retires it.

The architectural state is an 8-bit program counter, seven general registers and a four-bit status register. The status register can be read through register code 7, but it can never be written that way. Arithmetic, logic, shift, compare, move, divide, load, store and jump operations are all implemented. A halt instruction freezes the core until the next reset.

For checking, a trace port pulses once for each retired instruction. It shows that instruction's address together with the full register state after the instruction. Filling the memory before reset is the job of the surrounding system.

Top module: `cpu16_core`

## Requirements
- R1: While rst_ni is low, all registers and the status word read as zero, halted_o and trace_valid_o are 0, and mem_addr_o is 0. The first fetch after reset reads word 0.
- R2: Instruction fields are placed as follows.
  - The opcode is in bits 15:11.
  - Three-register operations place operand A in bits 8:6, operand B in bits 5:3 and the destination in bits 2:0.
  - The three-register operations and their opcodes are add (10000), sub (10001) and mul (10110).
  - add and mul write the low 16 bits of the result and set V (status bit 3) when the result does not fit in 16 bits.
  - sub writes 0 and sets V when B > A.
- R3: The following bitwise operations use the same three-register layout: xor (11010), or (11011) and and (11100). not (11101) writes ~src, with the source in bits 5:3 and the destination in bits 2:0.
- R4: Move-immediate (10010) writes {8'h00, imm}, with the register in bits 10:8 and imm in bits 7:0. Move-register (10011) copies the register named in bits 5:3 into the register named in bits 2:0. Source code 7 reads the status word {12'b0, V, L, G, E}.
- R5: Compare (11110) uses operands in bits 5:3 and 2:0 and sets exactly one of L (bit 2, A<B), G (bit 1, A>B) or E (bit 0, A==B). Every other instruction writes its own flags and clears all the rest, so a non-arithmetic, non-compare instruction leaves the status word at 0.
- R6: Shift right (11000) and shift left (11001) shift the register in bits 10:8 logically by the 8-bit amount in bits 7:0. A shift of 16 or more gives 0.
- R7: Divide (10111) divides the register in bits 5:3 by the register in bits 2:0. It writes the quotient to R0 and the remainder to R1. A zero divisor writes 0 to both and sets V.
- R8: Load (10100) and store (10101) access the word at address bits 7:0, with the register in bits 10:8. A store drives mem_we_o for one cycle.
- R9: Jumps load PC with bits 7:0:
  - 11111 always jumps;
  - 01100 jumps if L is set;
  - 01101 jumps if G is set;
  - 01111 jumps if E is set.
  The test uses the flags left by the previous instruction. An untaken jump, or any non-jump instruction, advances the PC by 1, wrapping at 255.
- R10: A register write whose destination code is 7 is discarded.
- R11: Halt (01010) retires once. After that, halted_o stays at 1, and neither trace pulses nor memory writes occur until reset.
- R12: Each instruction takes two cycles. trace_valid_o is high for exactly one cycle per retired instruction. In that cycle, trace_pc_o is the address of that instruction, and trace_state_o holds R0 in bits 15:0 up to R6 in bits 111:96, with the status word in bits 127:112.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mem_rdata_i | input | 16 | Combinational read data for mem_addr_o |
| mem_addr_o | output | 8 | Word address for fetch, load or store |
| mem_wdata_o | output | 16 | Store data |
| mem_we_o | output | 1 | Store strobe |
| halted_o | output | 1 | High once halt has retired |
| trace_valid_o | output | 1 | One-cycle pulse per retired instruction |
| trace_pc_o | output | 8 | Address of the retired instruction |
| trace_state_o | output | 128 | Registers R0..R6 and the status word after retirement |

## Verification
The hardest conditions to reach are the interactions between the status word and the instruction that follows it. Examples are a conditional jump that sees flags produced by a compare, a move that reads a freshly set V bit, and a write aimed at code 7 that must vanish. Random register contents alone rarely line these up. Directed programs therefore chain compare, jump, overflow and move-from-status instructions back to back. Randomly generated straight-line programs cover the rest. These programs draw register code 7 freely and include zero divisors and shift amounts of 16 or more. Every retirement is compared with an instruction-level model kept in the bench.

// File: rtl/cpu16_pkg.sv
package cpu16_pkg;
  parameter int unsigned XLEN   = 16;
  parameter int unsigned AW     = 8;
  parameter int unsigned NGPR   = 7;
  parameter int unsigned RIDX_W = 3;
  parameter int unsigned OP_W   = 5;
  parameter int unsigned FLAG_W = 4;
  localparam int unsigned NSLOT = NGPR + 1;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 5'b10000, OP_SUB  = 5'b10001, OP_MOVI = 5'b10010,
    OP_MOVR = 5'b10011, OP_LD   = 5'b10100, OP_ST   = 5'b10101,
    OP_MUL  = 5'b10110, OP_DIV  = 5'b10111, OP_SHR  = 5'b11000,
    OP_SHL  = 5'b11001, OP_XOR  = 5'b11010, OP_OR   = 5'b11011,
    OP_AND  = 5'b11100, OP_NOT  = 5'b11101, OP_CMP  = 5'b11110,
    OP_JMP  = 5'b11111, OP_JLT  = 5'b01100, OP_JGT  = 5'b01101,
    OP_JEQ  = 5'b01111, OP_HLT  = 5'b01010
  } opcode_e;

  typedef struct packed {
    logic v;
    logic l;
    logic g;
    logic e;
  } flags_t;

  typedef enum logic [1:0] {ST_FETCH, ST_EXEC, ST_HALT} state_e;
endpackage

// File: rtl/cpu16_alu.sv
module cpu16_alu
  import cpu16_pkg::*;
(
  input  opcode_e         op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [AW-1:0]   imm_i,
  output logic [XLEN-1:0] res_o,
  output logic [XLEN-1:0] rem_o,
  output flags_t          flags_o
);
  logic [XLEN:0]     sum;
  logic [2*XLEN-1:0] prod;

  assign sum  = {1'b0, a_i} + {1'b0, b_i};
  assign prod = {{XLEN{1'b0}}, a_i} * {{XLEN{1'b0}}, b_i};

  always_comb begin
    res_o   = '0;
    rem_o   = '0;
    flags_o = '0;
    unique case (op_i)
      OP_ADD: begin res_o = sum[XLEN-1:0]; flags_o.v = sum[XLEN]; end
      OP_SUB: begin
        if (b_i > a_i) flags_o.v = 1'b1;
        else           res_o = a_i - b_i;
      end
      OP_MUL: begin res_o = prod[XLEN-1:0]; flags_o.v = |prod[2*XLEN-1:XLEN]; end
      OP_DIV: begin
        if (b_i == '0) flags_o.v = 1'b1;
        else begin res_o = a_i / b_i; rem_o = a_i % b_i; end
      end
      OP_SHR:  res_o = a_i >> imm_i;
      OP_SHL:  res_o = a_i << imm_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_AND:  res_o = a_i & b_i;
      OP_NOT:  res_o = ~a_i;
      OP_MOVI: res_o = {{(XLEN-AW){1'b0}}, imm_i};
      OP_MOVR: res_o = a_i;
      OP_CMP: begin
        flags_o.l = a_i < b_i;
        flags_o.g = a_i > b_i;
        flags_o.e = a_i == b_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cpu16_regfile.sv
module cpu16_regfile
  import cpu16_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [RIDX_W-1:0]     ra_a_i,
  input  logic [RIDX_W-1:0]     ra_b_i,
  output logic [XLEN-1:0]       rd_a_o,
  output logic [XLEN-1:0]       rd_b_o,
  input  logic                  we0_i,
  input  logic [RIDX_W-1:0]     wa0_i,
  input  logic [XLEN-1:0]       wd0_i,
  input  logic                  we1_i,
  input  logic [RIDX_W-1:0]     wa1_i,
  input  logic [XLEN-1:0]       wd1_i,
  input  logic                  flags_we_i,
  input  flags_t                flags_i,
  output flags_t                flags_o,
  output logic [NSLOT*XLEN-1:0] dump_o
);
  logic [XLEN-1:0] slot [NSLOT];
  flags_t          flags_q;

  for (genvar i = 0; i < NGPR; i++) begin : g_gpr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                         slot[i] <= '0;
      else if (we0_i && wa0_i == RIDX_W'(i))               slot[i] <= wd0_i;
      else if (we1_i && wa1_i == RIDX_W'(i))               slot[i] <= wd1_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flags_q <= '0;
    else if (flags_we_i) flags_q <= flags_i;
  end

  // code NGPR reads the status word; writes to it match no slot above
  assign slot[NGPR] = {{(XLEN-FLAG_W){1'b0}}, flags_q};
  assign rd_a_o  = slot[ra_a_i];
  assign rd_b_o  = slot[ra_b_i];
  assign flags_o = flags_q;

  for (genvar i = 0; i < NSLOT; i++) begin : g_dump
    assign dump_o[i*XLEN +: XLEN] = slot[i];
  end

  assert_port_conflict_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we0_i && we1_i) |-> (wa0_i != wa1_i));
endmodule

// File: rtl/cpu16_core.sv
module cpu16_core
  import cpu16_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [XLEN-1:0]       mem_rdata_i,
  output logic [AW-1:0]         mem_addr_o,
  output logic [XLEN-1:0]       mem_wdata_o,
  output logic                  mem_we_o,
  output logic                  halted_o,
  output logic                  trace_valid_o,
  output logic [AW-1:0]         trace_pc_o,
  output logic [NSLOT*XLEN-1:0] trace_state_o
);
  state_e          state_q;
  logic [AW-1:0]   pc_q, trace_pc_q, next_pc;
  logic [XLEN-1:0] ir_q;
  logic            trace_valid_q;

  opcode_e            op;
  logic               exec;
  logic [RIDX_W-1:0]  ra, rb, wa0;
  logic               we0, we1, is_ld, is_st, is_halt, taken;
  logic [XLEN-1:0]    rd_a, rd_b, alu_res, alu_rem, wd0;
  logic [AW-1:0]      imm;
  flags_t             cur_flags, alu_flags;

  assign op   = opcode_e'(ir_q[XLEN-1 -: OP_W]);
  assign imm  = ir_q[AW-1:0];
  assign exec = (state_q == ST_EXEC);

  always_comb begin
    ra = ir_q[10:8]; rb = ir_q[2:0]; wa0 = ir_q[10:8];
    we0 = 1'b0; we1 = 1'b0; is_ld = 1'b0; is_st = 1'b0;
    is_halt = 1'b0; taken = 1'b0;
    unique case (op)
      OP_ADD, OP_SUB, OP_MUL, OP_XOR, OP_OR, OP_AND: begin
        ra = ir_q[8:6]; rb = ir_q[5:3]; wa0 = ir_q[2:0]; we0 = 1'b1;
      end
      OP_MOVI, OP_SHR, OP_SHL: we0 = 1'b1;
      OP_LD:  begin we0 = 1'b1; is_ld = 1'b1; end
      OP_ST:  is_st = 1'b1;
      OP_MOVR, OP_NOT: begin ra = ir_q[5:3]; wa0 = ir_q[2:0]; we0 = 1'b1; end
      OP_CMP: ra = ir_q[5:3];
      OP_DIV: begin ra = ir_q[5:3]; wa0 = '0; we0 = 1'b1; we1 = 1'b1; end
      OP_JMP: taken = 1'b1;
      OP_JLT: taken = cur_flags.l;
      OP_JGT: taken = cur_flags.g;
      OP_JEQ: taken = cur_flags.e;
      OP_HLT: is_halt = 1'b1;
      default: ;
    endcase
  end

  assign wd0     = is_ld ? mem_rdata_i : alu_res;
  assign next_pc = is_halt ? pc_q : (taken ? imm : pc_q + AW'(1));

  cpu16_alu u_alu (
    .op_i(op), .a_i(rd_a), .b_i(rd_b), .imm_i(imm),
    .res_o(alu_res), .rem_o(alu_rem), .flags_o(alu_flags)
  );

  cpu16_regfile u_rf (
    .clk_i, .rst_ni,
    .ra_a_i(ra), .ra_b_i(rb), .rd_a_o(rd_a), .rd_b_o(rd_b),
    .we0_i(exec && we0), .wa0_i(wa0), .wd0_i(wd0),
    .we1_i(exec && we1), .wa1_i(RIDX_W'(1)), .wd1_i(alu_rem),
    .flags_we_i(exec), .flags_i(alu_flags), .flags_o(cur_flags),
    .dump_o(trace_state_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_FETCH;
      pc_q          <= '0;
      ir_q          <= '0;
      trace_valid_q <= 1'b0;
      trace_pc_q    <= '0;
    end else begin
      trace_valid_q <= 1'b0;
      unique case (state_q)
        ST_FETCH: begin ir_q <= mem_rdata_i; state_q <= ST_EXEC; end
        ST_EXEC: begin
          pc_q          <= next_pc;
          trace_valid_q <= 1'b1;
          trace_pc_q    <= pc_q;
          state_q       <= is_halt ? ST_HALT : ST_FETCH;
        end
        default: ;
      endcase
    end
  end

  assign mem_addr_o    = (exec && (is_ld || is_st)) ? imm : pc_q;
  assign mem_wdata_o   = rd_a;
  assign mem_we_o      = exec && is_st;
  assign halted_o      = (state_q == ST_HALT);
  assign trace_valid_o = trace_valid_q;
  assign trace_pc_o    = trace_pc_q;

  assert_trace_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trace_valid_o |=> !trace_valid_o);
  assert_halt_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> (halted_o && !trace_valid_o && !mem_we_o));
  assert_cmp_onehot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trace_valid_o |-> $onehot0(trace_state_o[NGPR*XLEN +: 3]));
  assert_store_retires_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> trace_valid_o);
endmodule

// File: tb/cpu16_core_test.sv
`timescale 1ns/1ps
module cpu16_core_test;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [15:0]  mem_rdata, mem_wdata;
  logic [7:0]   mem_addr, trace_pc;
  logic         mem_we, halted, trace_valid;
  logic [127:0] trace_state;

  logic [15:0] mem  [256];
  logic [15:0] mmem [256];
  logic [15:0] mreg [8];
  logic [7:0]  mpc;
  bit          mhalt;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  cpu16_core uut (
    .clk_i(clk), .rst_ni(rst_ni), .mem_rdata_i(mem_rdata), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_we_o(mem_we), .halted_o(halted),
    .trace_valid_o(trace_valid), .trace_pc_o(trace_pc), .trace_state_o(trace_state)
  );

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] = mem_wdata;

  task automatic check(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL R12 watchdog: actual hung expected finished");
    summary();
  end

  function automatic logic [15:0] ea(input logic [4:0] op, input int r1, input int r2, input int r3);
    return {op, 2'b00, 3'(r1), 3'(r2), 3'(r3)};
  endfunction
  function automatic logic [15:0] eb(input logic [4:0] op, input int r, input int v);
    return {op, 3'(r), 8'(v)};
  endfunction
  function automatic logic [15:0] ec(input logic [4:0] op, input int r1, input int r2);
    return {op, 5'b0, 3'(r1), 3'(r2)};
  endfunction
  function automatic logic [15:0] ee(input logic [4:0] op, input int a);
    return {op, 3'b0, 8'(a)};
  endfunction

  task automatic put(input int a, input logic [15:0] w);
    mem[a] = w; mmem[a] = w;
  endtask
  task automatic clear_mem();
    for (int i = 0; i < 256; i++) put(i, 16'h0);
  endtask

  function automatic logic [127:0] mstate();
    logic [127:0] s;
    for (int i = 0; i < 8; i++) s[16*i +: 16] = mreg[i];
    return s;
  endfunction

  // instruction-level reference model
  task automatic model_step(output string tag, output logic [7:0] xpc);
    logic [15:0] ins, a, b, res;
    logic [16:0] s;
    logic [31:0] p;
    logic [3:0]  nf, f;
    logic [7:0]  npc;
    logic [2:0]  wd;
    bit          wr;
    ins = mmem[mpc]; xpc = mpc; f = mreg[7][3:0];
    nf = 0; npc = mpc + 8'd1; wr = 0; wd = 0; res = 0; tag = "R5";
    case (ins[15:11])
      5'b10000: begin a = mreg[ins[8:6]]; b = mreg[ins[5:3]]; s = {1'b0,a} + {1'b0,b};
        res = s[15:0]; nf[3] = s[16]; wd = ins[2:0]; wr = 1; tag = "R2"; end
      5'b10001: begin a = mreg[ins[8:6]]; b = mreg[ins[5:3]];
        if (b > a) begin res = 0; nf[3] = 1; end else res = a - b;
        wd = ins[2:0]; wr = 1; tag = "R2"; end
      5'b10110: begin a = mreg[ins[8:6]]; b = mreg[ins[5:3]]; p = {16'b0,a} * {16'b0,b};
        res = p[15:0]; nf[3] = |p[31:16]; wd = ins[2:0]; wr = 1; tag = "R2"; end
      5'b11010: begin res = mreg[ins[8:6]] ^ mreg[ins[5:3]]; wd = ins[2:0]; wr = 1; tag = "R3"; end
      5'b11011: begin res = mreg[ins[8:6]] | mreg[ins[5:3]]; wd = ins[2:0]; wr = 1; tag = "R3"; end
      5'b11100: begin res = mreg[ins[8:6]] & mreg[ins[5:3]]; wd = ins[2:0]; wr = 1; tag = "R3"; end
      5'b11101: begin res = ~mreg[ins[5:3]]; wd = ins[2:0]; wr = 1; tag = "R3"; end
      5'b10010: begin res = {8'h00, ins[7:0]}; wd = ins[10:8]; wr = 1; tag = "R4"; end
      5'b10011: begin res = mreg[ins[5:3]]; wd = ins[2:0]; wr = 1; tag = "R4"; end
      5'b11110: begin a = mreg[ins[5:3]]; b = mreg[ins[2:0]];
        nf[2] = a < b; nf[1] = a > b; nf[0] = a == b; tag = "R5"; end
      5'b11000: begin res = mreg[ins[10:8]] >> ins[7:0]; wd = ins[10:8]; wr = 1; tag = "R6"; end
      5'b11001: begin res = mreg[ins[10:8]] << ins[7:0]; wd = ins[10:8]; wr = 1; tag = "R6"; end
      5'b10111: begin a = mreg[ins[5:3]]; b = mreg[ins[2:0]]; tag = "R7";
        if (b == 0) begin nf[3] = 1; mreg[0] = 0; mreg[1] = 0; end
        else begin mreg[0] = a / b; mreg[1] = a % b; end end
      5'b10100: begin res = mmem[ins[7:0]]; wd = ins[10:8]; wr = 1; tag = "R8"; end
      5'b10101: begin mmem[ins[7:0]] = mreg[ins[10:8]]; tag = "R8"; end
      5'b11111: begin npc = ins[7:0]; tag = "R9"; end
      5'b01100: begin if (f[2]) npc = ins[7:0]; tag = "R9"; end
      5'b01101: begin if (f[1]) npc = ins[7:0]; tag = "R9"; end
      5'b01111: begin if (f[0]) npc = ins[7:0]; tag = "R9"; end
      5'b01010: begin npc = mpc; mhalt = 1; tag = "R11"; end
      default: ;
    endcase
    if (wr) begin
      if (wd == 3'd7) tag = "R10";
      else mreg[wd] = res;
    end
    mreg[7] = {12'b0, nf};
    mpc = npc;
  endtask

  task automatic run_prog(input int max_instr);
    string tag;
    logic [7:0] xpc;
    rst_ni = 1'b0;
    for (int i = 0; i < 8; i++) mreg[i] = 0;
    mpc = 0; mhalt = 0;
    repeat (2) @(negedge clk);
    check("R1", "reset state", trace_state, 128'h0);
    check("R1", "reset halted/valid", {halted, trace_valid}, 2'b00);
    check("R1", "reset fetch address", mem_addr, 8'h00);
    rst_ni = 1'b1;
    for (int n = 0; n < max_instr && !mhalt; n++) begin
      int w = 0;
      do begin @(negedge clk); w++; end while (!trace_valid && w < 8);
      if (!trace_valid) begin
        check("R12", "retire timeout", 0, 1);
        return;
      end
      check("R12", "cycles per instruction", w, 2);
      model_step(tag, xpc);
      check(tag, "R12 trace pc", trace_pc, xpc);
      check(tag, "R12 trace state", trace_state, mstate());
    end
    if (mhalt) begin
      bit seen = 0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (trace_valid || mem_we || !halted) seen = 1;
      end
      check("R11", "halt holds quiet", seen, 0);
    end
    begin
      int bad = 0;
      for (int i = 0; i < 256; i++) if (mem[i] !== mmem[i]) bad++;
      check("R8", "memory image mismatches", bad, 0);
    end
  endtask

  task automatic gen_random(input int n);
    clear_mem();
    for (int i = 192; i < 256; i++) put(i, 16'($urandom));
    for (int i = 0; i < n - 1; i++) begin
      int sel = $urandom_range(0, 14);
      int r1 = $urandom_range(0, 7), r2 = $urandom_range(0, 7), r3 = $urandom_range(0, 7);
      int im = $urandom_range(0, 255);
      int sh = ($urandom_range(0, 3) == 0) ? im : $urandom_range(0, 16);
      int ad = 192 + $urandom_range(0, 63);
      case (sel)
        0:  put(i, ea(5'b10000, r1, r2, r3));
        1:  put(i, ea(5'b10001, r1, r2, r3));
        2:  put(i, ea(5'b10110, r1, r2, r3));
        3:  put(i, ec(5'b10111, r1, r2));
        4:  put(i, eb(5'b11000, r1, sh));
        5:  put(i, eb(5'b11001, r1, sh));
        6:  put(i, ea(5'b11010, r1, r2, r3));
        7:  put(i, ea(5'b11011, r1, r2, r3));
        8:  put(i, ea(5'b11100, r1, r2, r3));
        9:  put(i, ec(5'b11101, r1, r2));
        10: put(i, ec(5'b11110, r1, r2));
        11: put(i, eb(5'b10010, r1, im));
        12: put(i, ec(5'b10011, r1, r2));
        13: put(i, eb(5'b10100, r1, ad));
        default: put(i, eb(5'b10101, r1, ad));
      endcase
    end
    put(n - 1, ee(5'b01010, 0));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // directed: arithmetic edges, status reads, code-7 writes (R2 R4 R6 R7 R10)
    clear_mem();
    put(0,  eb(5'b10010, 1, 255));
    put(1,  eb(5'b11001, 1, 8));
    put(2,  eb(5'b10010, 2, 255));
    put(3,  ea(5'b10000, 1, 1, 3));
    put(4,  ea(5'b10001, 2, 1, 4));
    put(5,  ea(5'b10110, 1, 1, 5));
    put(6,  ec(5'b10111, 1, 0));
    put(7,  ec(5'b10011, 7, 6));
    put(8,  ec(5'b11110, 2, 2));
    put(9,  ec(5'b10011, 7, 5));
    put(10, eb(5'b10010, 7, 5));
    put(11, ea(5'b10000, 1, 2, 7));
    put(12, eb(5'b11000, 1, 16));
    put(13, ec(5'b10111, 2, 5));
    put(14, eb(5'b10101, 2, 200));
    put(15, eb(5'b10100, 6, 200));
    put(16, ee(5'b01010, 0));
    run_prog(40);
    // directed: flag-driven jumps (R9)
    clear_mem();
    put(0,  eb(5'b10010, 1, 5));
    put(1,  eb(5'b10010, 2, 10));
    put(2,  ec(5'b11110, 1, 2));
    put(3,  ee(5'b01100, 6));
    put(4,  eb(5'b10010, 3, 1));
    put(5,  ee(5'b01010, 0));
    put(6,  ee(5'b01101, 4));
    put(7,  ec(5'b11110, 2, 2));
    put(8,  ee(5'b01111, 10));
    put(9,  ee(5'b01010, 0));
    put(10, ec(5'b11110, 2, 1));
    put(11, ee(5'b01101, 14));
    put(12, ee(5'b01010, 0));
    put(14, ec(5'b11110, 2, 1));
    put(15, ee(5'b01100, 12));
    put(16, ee(5'b01111, 12));
    put(17, ee(5'b11111, 4));
    run_prog(40);
    // random straight-line programs
    for (int t = 0; t < 8; t++) begin
      gen_random(48);
      run_prog(60);
    end
    summary();
  end
endmodule